// File: doc/BRIEF.md
# Low-Power Secondary Clock Switch Controller

This block chooses which of three oscillators drives the system clock: the primary oscillator, the internal RC oscillator, or a slow 32.768 kHz secondary oscillator. Software writes a 2-bit source select value. Before the value is used, the block combines it with the secondary-oscillator enable bit. A switch starts only when the combined value differs from the select value currently held.

During a switch, the four-phase instruction-cycle generator is frozen in its first phase. The outgoing clock is allowed to finish its high time and is then gated low. The block counts a fixed number of falling edges of the incoming clock, waits one more incoming period, and then connects the incoming clock to the output. At that point it updates the oscillator-start-up and secondary-running flags and drives a shutdown request to the primary oscillator while the secondary clock is in use.

All three oscillators are brought into a fast control clock `clk` through two-flop synchronisers and handled there as sampled levels. The system clock output is a registered copy of the selected oscillator.

Top module: `clksw_top`

## Requirements
- R1: After reset the held select value is 00, `switching`, `sec_run` and `pri_off` are 0, `q_phase` is 4'b0001 (Q1), and `osts` is 1 exactly when the configured source is the primary oscillator.
- R2: With `sec_en` = 0 a written select value has its bit 0 forced to 0. A write of 01 therefore resolves to 00, and a write of 11 resolves to 10.
- R3: With `sec_en` = 1 the written value is used unchanged. Select values with bit 0 = 1 choose the secondary oscillator, and 10 chooses the RC oscillator. Value 00 chooses the RC oscillator when `osc_cfg` is 3'b100 or 3'b101, and the primary oscillator for any other `osc_cfg`.
- R4: A write whose resolved value equals the held select value starts no switch. `switching` stays 0, and `sel_q` and the flags keep their values.
- R5: A write whose resolved value differs from the held value raises `switching` in the clock cycle after `sel_we` is sampled. It also clears `osts`, `sec_run` and `pri_off`.
- R6: While `switching` is 1, `q_phase` is held at Q1 from the second cycle of the switch onward, and `sys_clk` never makes a 0-to-1 transition.
- R7: A switch ends only after the ninth falling edge of the target oscillator counted from the write: eight edges are counted, then one further period passes.
- R8: When a switch ends, `sel_q` takes the resolved value. `sec_run` and `pri_off` become 1 exactly when the new source is the secondary oscillator, and `osts` becomes 1 exactly when the new source is the primary oscillator.
- R9: Select writes that arrive while `switching` is 1 are ignored. The switch finishes with the value resolved at its start.
- R10: Outside a switch, `q_phase` steps Q1→Q2→Q3→Q4→Q1 (4'b0001, 0010, 0100, 1000) once per falling edge of the active oscillator. `sys_clk` follows that oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast control clock that samples the oscillators |
| rst | input | 1 | Synchronous active-high reset |
| osc_pri | input | 1 | Primary oscillator |
| osc_rc | input | 1 | Internal RC oscillator |
| osc_sec | input | 1 | 32.768 kHz secondary oscillator |
| sel_wdata | input | 2 | Select value written by software |
| sel_we | input | 1 | Write strobe for `sel_wdata` |
| sec_en | input | 1 | Secondary oscillator enable bit |
| osc_cfg | input | 3 | Oscillator configuration field used for select value 00 |
| sys_clk | output | 1 | Selected system clock |
| q_phase | output | 4 | One-hot instruction-cycle phases Q1..Q4 (bit 0 is Q1) |
| sel_q | output | 2 | Select value currently held |
| osts | output | 1 | Primary oscillator is the running clock |
| sec_run | output | 1 | Secondary oscillator is the running clock |
| pri_off | output | 1 | Shutdown request to the primary oscillator |
| switching | output | 1 | A clock handover is in progress |

## Verification
Two events can fall in the same control cycle: a select write, and the last step of a handover (the edge count reaching its limit or the final output connection). The bench provokes this by placing a second write at a random offset inside every switch that is allowed one. Some of these writes land during the counting phase, and some land on the completion cycle itself. A write is judged correct when the held select value and the flags after the switch match the value resolved at the first write, and when the counted target edges equal nine.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_RC  = 2'd1,
    SRC_SEC = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_DELAY = 2'd2
  } st_e;

  localparam int NUM_SRC = 3;

  // Map a select value and the configuration field to a physical source.
  function automatic src_e sel_to_src(input logic [1:0] sel, input logic [2:0] cfg);
    if (sel[0]) return SRC_SEC;
    if (sel[1]) return SRC_RC;
    if ((cfg == 3'b100) || (cfg == 3'b101)) return SRC_RC;
    return SRC_PRI;
  endfunction

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/clksw_resolve.sv
module clksw_resolve (
  input  logic [1:0] wdata,
  input  logic       sec_en,
  input  logic [1:0] cur,
  output logic [1:0] res,
  output logic       differs
);

  // Without the secondary enable, any request for it collapses onto bit 0 = 0.
  always_comb begin
    res     = sec_en ? wdata : {wdata[1], 1'b0};
    differs = (res != cur);
  end

endmodule

// File: rtl/clksw_phase.sv
module clksw_phase #(
  parameter int PHASES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              adv,
  output logic [PHASES-1:0] q
);

  localparam logic [PHASES-1:0] FIRST = PHASES'(1);

  always_ff @(posedge clk) begin
    if (rst || hold) q <= FIRST;
    else if (adv)    q <= {q[PHASES-2:0], q[PHASES-1]};
  end

  assert_q_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(q) == 1);

  assert_hold_q1_R6: assert property (@(posedge clk) disable iff (rst)
    (hold && $past(hold)) |-> (q == FIRST));

endmodule

// File: rtl/clksw_top.sv
module clksw_top
  import clksw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_EDGES  = 8,
  parameter int DELAY_EDGES = 1,
  parameter int PHASES      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_pri,
  input  logic              osc_rc,
  input  logic              osc_sec,
  input  logic [1:0]        sel_wdata,
  input  logic              sel_we,
  input  logic              sec_en,
  input  logic [2:0]        osc_cfg,
  output logic              sys_clk,
  output logic [PHASES-1:0] q_phase,
  output logic [1:0]        sel_q,
  output logic              osts,
  output logic              sec_run,
  output logic              pri_off,
  output logic              switching
);

  localparam int TOTAL = HOLD_EDGES + DELAY_EDGES;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] CNT_TOTAL = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] CNT_HOLD  = CNT_W'(HOLD_EDGES);

  logic [NUM_SRC-1:0] osc_raw, osc_s, osc_p, fall;
  st_e                state;
  src_e               cur_src, tgt_src;
  logic [1:0]         tgt_sel;
  logic [CNT_W-1:0]   cnt;
  logic [1:0]         res;
  logic               differs;
  logic               fall_tgt;
  logic               finish;

  assign osc_raw = {osc_sec, osc_rc, osc_pri};

  clksw_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (osc_raw),
    .q   (osc_s)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_edge
    always_ff @(posedge clk) begin
      if (rst) osc_p[g] <= 1'b0;
      else     osc_p[g] <= osc_s[g];
    end
    assign fall[g] = osc_p[g] & ~osc_s[g];
  end

  clksw_resolve u_res (
    .wdata   (sel_wdata),
    .sec_en  (sec_en),
    .cur     (sel_q),
    .res     (res),
    .differs (differs)
  );

  assign fall_tgt  = fall[tgt_src];
  assign finish    = (state == ST_DELAY) && (cnt == CNT_TOTAL) && !sys_clk;
  assign switching = (state != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      sel_q   <= 2'b00;
      tgt_sel <= 2'b00;
      cur_src <= sel_to_src(2'b00, osc_cfg);
      tgt_src <= sel_to_src(2'b00, osc_cfg);
      cnt     <= '0;
      osts    <= (sel_to_src(2'b00, osc_cfg) == SRC_PRI);
      sec_run <= 1'b0;
      pri_off <= 1'b0;
      sys_clk <= 1'b0;
    end else begin
      // Outgoing clock may finish its high time, then stays low until handover.
      if (state == ST_RUN) sys_clk <= osc_s[cur_src];
      else                 sys_clk <= sys_clk & osc_s[cur_src];

      unique case (state)
        ST_RUN: begin
          if (sel_we) begin
            tgt_sel <= res;
            if (differs) begin
              tgt_src <= sel_to_src(res, osc_cfg);
              state   <= ST_HOLD;
              cnt     <= '0;
              osts    <= 1'b0;
              sec_run <= 1'b0;
              pri_off <= 1'b0;
            end
          end
        end
        ST_HOLD: begin
          if (fall_tgt) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_HOLD - 1'b1) state <= ST_DELAY;
          end
        end
        ST_DELAY: begin
          if (fall_tgt && (cnt != CNT_TOTAL)) cnt <= cnt + 1'b1;
          if (finish) begin
            state   <= ST_RUN;
            sel_q   <= tgt_sel;
            cur_src <= tgt_src;
            cnt     <= '0;
            osts    <= (tgt_src == SRC_PRI);
            sec_run <= (tgt_src == SRC_SEC);
            pri_off <= (tgt_src == SRC_SEC);
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  clksw_phase #(.PHASES(PHASES)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .hold (switching),
    .adv  (fall[cur_src]),
    .q    (q_phase)
  );

  assert_resolve_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && sel_we && !sec_en) |=> !tgt_sel[0]);

  assert_osts_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN) |-> (!osts && !sec_run));

  assert_mux_low_R6: assert property (@(posedge clk) disable iff (rst)
    (cur_src != $past(cur_src)) |-> !sys_clk);

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_TOTAL);

  assert_full_count_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(state) != ST_RUN && state == ST_RUN) |-> ($past(cnt) == CNT_TOTAL));

  assert_pri_off_R8: assert property (@(posedge clk) disable iff (rst)
    pri_off == sec_run);

  assert_ignore_write_R9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN && sel_we) |=> $stable(tgt_sel));

endmodule

// File: tb/tb_clksw_top.sv
`timescale 1ns/1ps
module tb_clksw_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] osc = 3'b000;
  logic [1:0] sel_wdata = 2'b00;
  logic       sel_we = 1'b0;
  logic       sec_en = 1'b0;
  logic [2:0] osc_cfg = 3'b000;
  logic       sys_clk;
  logic [3:0] q_phase;
  logic [1:0] sel_q;
  logic       osts, sec_run, pri_off, switching;

  int checks = 0;
  int fails  = 0;
  logic [1:0] model_sel;

  always #2 clk = ~clk;

  clksw_top dut (
    .clk(clk), .rst(rst), .osc_pri(osc[0]), .osc_rc(osc[1]), .osc_sec(osc[2]),
    .sel_wdata(sel_wdata), .sel_we(sel_we), .sec_en(sec_en), .osc_cfg(osc_cfg),
    .sys_clk(sys_clk), .q_phase(q_phase), .sel_q(sel_q), .osts(osts),
    .sec_run(sec_run), .pri_off(pri_off), .switching(switching)
  );

  // Free-running oscillators, half periods 5, 7 and 13 control cycles.
  initial begin
    int c0 = 0, c1 = 0, c2 = 0;
    forever begin
      @(posedge clk); #1;
      c0++; c1++; c2++;
      if (c0 == 5)  begin c0 = 0; osc[0] = ~osc[0]; end
      if (c1 == 7)  begin c1 = 0; osc[1] = ~osc[1]; end
      if (c2 == 13) begin c2 = 0; osc[2] = ~osc[2]; end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] resolve(input logic [1:0] wd, input logic en);
    return en ? wd : {wd[1], 1'b0};
  endfunction

  // 0 primary, 1 RC, 2 secondary
  function automatic int src_of(input logic [1:0] s, input logic [2:0] cfg);
    if (s[0]) return 2;
    if (s[1]) return 1;
    if (cfg == 3'b100 || cfg == 3'b101) return 1;
    return 0;
  endfunction

  task automatic do_reset(input logic [2:0] cfg);
    @(negedge clk);
    osc_cfg = cfg; rst = 1'b1; sel_we = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    model_sel = 2'b00;
    chk(sel_q == 2'b00, "R1 sel_q", sel_q, 0);
    chk(!switching && !sec_run && !pri_off, "R1 flags", {switching, sec_run, pri_off}, 0);
    chk(q_phase == 4'b0001, "R1 q_phase", q_phase, 1);
    chk(osts == (src_of(2'b00, cfg) == 0), "R1 osts", osts, src_of(2'b00, cfg) == 0);
  endtask

  task automatic xact(input logic [1:0] wd, input logic en, input bit mid, input string tag);
    logic [1:0] r;
    int tg, falls, n, mid_at, last_sys;
    bit sw, prev, prev_sys, hold_bad, seen, pv;
    r  = resolve(wd, en);
    tg = src_of(r, osc_cfg);
    sw = (r != model_sel);
    if (sw) begin
      pv = osc[tg];
      forever begin @(negedge clk); if (!pv && osc[tg]) break; pv = osc[tg]; end
    end
    @(negedge clk);
    sec_en = en; sel_wdata = wd; sel_we = 1'b1;
    prev = osc[tg];
    @(negedge clk);
    sel_we = 1'b0;
    chk(switching == sw, {tag, " R4/R5 switch start"}, switching, sw);
    if (!sw) begin
      repeat (3) @(negedge clk);
      chk(!switching && sel_q == model_sel, {tag, " R4 no switch, sel kept"}, sel_q, model_sel);
      return;
    end
    chk(!osts && !sec_run && !pri_off, {tag, " R5 flags cleared"}, {osts, sec_run, pri_off}, 0);
    falls = 0; n = 0; hold_bad = 0; prev_sys = sys_clk;
    if (osc[tg] != prev) begin if (prev) falls++; prev = osc[tg]; end
    mid_at = mid ? $urandom_range(1, 250) : -1;
    while (switching && n < 3000) begin
      @(negedge clk);
      n++;
      if (prev && !osc[tg]) falls++;
      prev = osc[tg];
      if (switching && q_phase != 4'b0001) hold_bad = 1;
      if (!prev_sys && sys_clk && switching) hold_bad = 1;
      prev_sys = sys_clk;
      if (switching && n == mid_at) begin
        sel_wdata = 2'($urandom_range(0, 3)); sec_en = 1'($urandom_range(0, 1)); sel_we = 1'b1;
      end else sel_we = 1'b0;
    end
    sel_we = 1'b0;
    chk(!hold_bad, {tag, " R6 Q1 held, no rising sys_clk"}, hold_bad, 0);
    chk(falls == 9, {tag, " R7 target falls"}, falls, 9);
    model_sel = r;
    chk(sel_q == r, {tag, " R8/R9 sel_q"}, sel_q, r);
    chk(sec_run == (tg == 2) && pri_off == (tg == 2), {tag, " R8 sec_run/pri_off"},
        {sec_run, pri_off}, {tg == 2, tg == 2});
    chk(osts == (tg == 0), {tag, " R8 osts"}, osts, tg == 0);
    chk(q_phase == 4'b0001, {tag, " R10 starts Q1"}, q_phase, 1);
    for (int k = 1; k <= 4; k++) begin
      logic [3:0] e;
      e = 4'b0001 << (k % 4);
      pv = osc[tg]; seen = 0; last_sys = 0;
      while (!seen) begin
        last_sys = sys_clk;
        @(negedge clk);
        if (pv && !osc[tg]) seen = 1;
        pv = osc[tg];
      end
      repeat (3) @(negedge clk);
      chk(q_phase == e, {tag, " R10 phase step"}, q_phase, e);
      chk(last_sys == 1 && sys_clk == 0, {tag, " R10 sys_clk follows source"},
          {last_sys[0], sys_clk}, 2);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset(3'b000);
    xact(2'b01, 1'b0, 0, "d1 R2");
    xact(2'b11, 1'b0, 0, "d2 R2");
    xact(2'b11, 1'b0, 0, "d3 R2");
    xact(2'b01, 1'b0, 0, "d4 R2");
    xact(2'b01, 1'b1, 1, "d5 R3 R9");
    xact(2'b10, 1'b1, 0, "d6 R3");
    xact(2'b11, 1'b1, 1, "d7 R3 R9");
    xact(2'b00, 1'b1, 0, "d8 R3");
    do_reset(3'b100);
    xact(2'b10, 1'b1, 0, "d9 R3");
    xact(2'b00, 1'b0, 0, "d10 R3");
    for (int i = 0; i < 30; i++) begin
      xact(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom_range(0, 1) == 1, "rnd");
    end
    summary();
    $finish;
  end

endmodule